// File: doc/BRIEF.md
# Level-Ordered Arbiter with Circular Tie-Break

This block chooses one owner among up to eight bus masters that compete for a single slave port. Every master raises a request bit and supplies a three-bit urgency level. Of the masters that request, only those at the highest level present are considered. Among those, the master found first when counting upward from the present owner, wrapping past the top index, is chosen. Masters with equal urgency therefore take turns, while a more urgent master always takes precedence.

The decision is captured in an owner register on the clock edge that samples the requests. That register is the block's output and also the starting point of the next circular search. A valid flag marks the cycles in which the owner was freshly chosen. The block is intended as the urgency path of a slave-port arbiter. Deciding when a new arbitration is allowed is left to the logic around it.

Top module: `prio_rr_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `owner_o` is 7 and `owner_vld_o` is 0, so master 0 is searched first.
- R2: Only a master whose `req_i` bit was set can be reported as owner with `owner_vld_o` high.
- R3: A numerically larger level is more urgent. The chosen master carries the largest level among all requesting masters.
- R4: Among requesting masters that share the largest level, the one whose index comes first after the present owner in the order owner+1, owner+2, and so on, wins.
- R5: When no tied master has an index above the present owner, the search wraps and the lowest-indexed tied master wins.
- R6: When no request is present, `owner_vld_o` is 0 one cycle later and `owner_o` keeps its value.
- R7: Outputs change only at the clock edge that samples the inputs. A change at the inputs is visible one cycle later and never earlier.
- R8: The level of master i is taken from `prio_i[3*i+2 : 3*i]`, with bit 3*i+2 as its most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Request bit per master |
| prio_i | input | 24 | Packed urgency levels, three bits per master |
| owner_o | output | 3 | Registered index of the chosen master |
| owner_vld_o | output | 1 | Registered flag: an owner was chosen at the last edge |

## Verification
The level comparison and the circular tie-break act on the same request vector in the same cycle. The critical case is a more urgent master at an index below the present owner while less urgent masters sit above it. The bench provokes this by sweeping every request vector under two level layouts: one spreads distinct levels, the other forms two tiers with several members each. Each outcome is judged against an arithmetic model that first finds the top level and then walks circularly from the owner the model itself tracks.

// File: rtl/prio_rr_pkg.sv
package prio_rr_pkg;

    localparam int unsigned NUM_MST = 8;
    localparam int unsigned LVL_W   = 3;
    localparam int unsigned IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;
    localparam int unsigned PRIO_W  = NUM_MST * LVL_W;

    typedef logic [NUM_MST-1:0] mvec_t;
    typedef logic [LVL_W-1:0]   lvl_t;
    typedef lvl_t [NUM_MST-1:0] lvl_arr_t;
    typedef logic [IDX_W-1:0]   idx_t;

    // result of the level comparison: the top level and who holds it
    typedef struct packed {
        lvl_t  top_lvl;
        mvec_t top_vec;
    } tier_t;

    // result of the circular search
    typedef struct packed {
        logic  vld;
        idx_t  idx;
        mvec_t onehot;
    } pick_t;

    localparam idx_t RESET_OWNER = idx_t'(NUM_MST - 1);

    // lowest set bit of a vector (0 when empty)
    function automatic idx_t first_set(input mvec_t v);
        idx_t r;
        r = '0;
        for (int i = NUM_MST - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    // indices strictly above the given owner
    function automatic mvec_t above_mask(input idx_t cur);
        mvec_t m;
        for (int i = 0; i < NUM_MST; i++) begin
            m[i] = (i > int'(cur));
        end
        return m;
    endfunction

endpackage

// File: rtl/prio_rr_tier.sv
module prio_rr_tier
    import prio_rr_pkg::*;
(
    input  mvec_t    req_i,
    input  lvl_arr_t lvl_i,
    output tier_t    tier_o
);

    lvl_t  best;
    mvec_t hit;

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (req_i[i] && (lvl_i[i] > best)) best = lvl_i[i];
        end
        for (int i = 0; i < NUM_MST; i++) begin
            hit[i] = req_i[i] && (lvl_i[i] == best);
        end
    end

    assign tier_o = '{top_lvl: best, top_vec: hit};

endmodule

// File: rtl/prio_rr_rotor.sv
module prio_rr_rotor
    import prio_rr_pkg::*;
(
    input  mvec_t cand_i,
    input  idx_t  cur_i,
    output pick_t pick_o
);

    mvec_t up_m;
    mvec_t up_c;
    mvec_t dn_c;
    mvec_t sel;

    assign up_m = above_mask(cur_i);
    assign up_c = cand_i & up_m;
    assign dn_c = cand_i & ~up_m;
    assign sel  = (|up_c) ? up_c : dn_c;

    always_comb begin
        pick_o.vld    = |sel;
        pick_o.idx    = first_set(sel);
        pick_o.onehot = pick_o.vld ? (mvec_t'(1) << pick_o.idx) : '0;
    end

    // R4: a pick is always one of the candidates, and any candidate yields a pick
    always_comb begin
        if (pick_o.vld) begin
            p_pick_in_cand_r4: assert (cand_i[pick_o.idx]);
        end
        if (|cand_i) begin
            p_cand_gives_pick_r4: assert (pick_o.vld);
        end
    end

endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter
    import prio_rr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MST-1:0]     req_i,
    input  logic [NUM_MST*LVL_W-1:0] prio_i,
    output logic [IDX_W-1:0]       owner_o,
    output logic                   owner_vld_o
);

    lvl_arr_t lvl;
    tier_t    tier;
    pick_t    pick;

    // R8: level field of master g
    for (genvar g = 0; g < NUM_MST; g++) begin : g_unpack
        assign lvl[g] = prio_i[g*LVL_W +: LVL_W];
    end

    prio_rr_tier u_tier (
        .req_i  (req_i),
        .lvl_i  (lvl),
        .tier_o (tier)
    );

    prio_rr_rotor u_rotor (
        .cand_i (tier.top_vec),
        .cur_i  (owner_o),
        .pick_o (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_o     <= RESET_OWNER;
            owner_vld_o <= 1'b0;
        end else begin
            owner_vld_o <= pick.vld;
            if (pick.vld) owner_o <= pick.idx;
        end
    end

    // R3: winner holds the top level, and no requester exceeds it
    always_comb begin
        if (pick.vld) begin
            p_top_level_r3: assert (lvl[pick.idx] == tier.top_lvl);
            for (int i = 0; i < NUM_MST; i++) begin
                if (req_i[i]) begin
                    p_no_higher_r3: assert (lvl[i] <= lvl[pick.idx]);
                end
            end
        end
    end

    // R2: a valid owner was requesting at the sampling edge
    p_win_requested_r2: assert property (@(posedge clk) disable iff (rst)
        owner_vld_o |-> ((($past(req_i) >> owner_o) & mvec_t'(1)) != '0));

    // R6: no request leaves owner stable and valid low
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(|req_i) |=> (!owner_vld_o && $stable(owner_o)));

    // R7: any request produces a valid owner one cycle later
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |=> owner_vld_o);

endmodule

// File: tb/prio_rr_arbiter_tb.sv
module prio_rr_arbiter_tb;
    import prio_rr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_MST-1:0] req = '0;
    logic [PRIO_W-1:0] prio = '0;
    logic [IDX_W-1:0]  owner;
    logic              owner_vld;

    int tests = 0;
    int fails = 0;
    int m_cur = NUM_MST - 1;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    prio_rr_arbiter u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .prio_i      (prio),
        .owner_o     (owner),
        .owner_vld_o (owner_vld)
    );

    function automatic int lvl_of(input logic [PRIO_W-1:0] p, input int i);
        return int'(p[i*LVL_W +: LVL_W]);
    endfunction

    // independent model: top level first, then circular walk from owner
    function automatic int model(input logic [NUM_MST-1:0] r,
                                 input logic [PRIO_W-1:0] p, input int cur);
        int best = -1;
        for (int i = 0; i < NUM_MST; i++)
            if (r[i] && lvl_of(p, i) > best) best = lvl_of(p, i);
        if (best < 0) return -1;
        for (int k = 1; k <= NUM_MST; k++) begin
            int j = (cur + k) % NUM_MST;
            if (r[j] && lvl_of(p, j) == best) return j;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input int act_o, input int exp_o,
                         input int act_v, input int exp_v);
        tests++;
        if (act_o != exp_o || act_v != exp_v) begin
            fails++;
            $display("FAIL %s: owner=%0d vld=%0d expected owner=%0d vld=%0d",
                     tag, act_o, act_v, exp_o, exp_v);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input logic [NUM_MST-1:0] r, input logic [PRIO_W-1:0] p,
                        input string tag);
        int e;
        int ev;
        req  = r;
        prio = p;
        e    = model(r, p, m_cur);
        ev   = (e >= 0) ? 1 : 0;
        if (e >= 0) m_cur = e;
        @(negedge clk);
        check(tag, int'(owner), m_cur, int'(owner_vld), ev);
    endtask

    function automatic logic [PRIO_W-1:0] flat_all(input int v);
        logic [PRIO_W-1:0] p;
        for (int i = 0; i < NUM_MST; i++) p[i*LVL_W +: LVL_W] = lvl_t'(v);
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: owner=%0d vld=%0d expected owner=%0d vld=%0d",
                     owner, owner_vld, m_cur, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [PRIO_W-1:0] p;
        repeat (3) @(negedge clk);
        check("R1 in reset", int'(owner), NUM_MST - 1, int'(owner_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'(owner), NUM_MST - 1, int'(owner_vld), 0);

        // R4: equal levels rotate 0,1,...,7,0,...
        for (int k = 0; k < 2 * NUM_MST; k++) begin
            step('1, flat_all(4), "R4 rotate");
            check("R4 rotate index", int'(owner), k % NUM_MST, 1, 1);
        end

        // R6: idle holds owner
        for (int k = 0; k < 3; k++) step('0, flat_all(5), "R6 idle hold");

        // R7: input change not visible before the edge
        req = 8'h01;
        #1;
        check("R7 no early change", int'(owner), m_cur, int'(owner_vld), 0);
        step(8'h01, flat_all(0), "R7 one cycle");

        // R2: single requester always wins, whatever its level
        for (int i = 0; i < NUM_MST; i++)
            step(mvec_t'(1) << i, flat_all(i % 8), "R2 single");

        // R5: owner at 6, tied masters only at 1 and 3 -> 1
        step(8'h40, flat_all(2), "R5 set owner");
        step(8'h0A, flat_all(2), "R5 wrap");
        check("R5 wrap index", int'(owner), 1, 1, 1);

        // R3: more urgent master below owner beats tied ones above
        p = flat_all(1);
        p[0*LVL_W +: LVL_W] = 3'd7;
        step(8'h70, flat_all(1), "R3 setup");
        step(8'h71, p, "R3 level over rotation");
        check("R3 level index", int'(owner), 0, 1, 1);

        // R3 R8: every request vector under two level layouts
        for (int r = 0; r < 256; r++) begin
            for (int i = 0; i < NUM_MST; i++)
                p[i*LVL_W +: LVL_W] = lvl_t'((r * 3 + i * 5) % 8);
            step(mvec_t'(r), p, "R3 R8 spread");
            for (int i = 0; i < NUM_MST; i++)
                p[i*LVL_W +: LVL_W] = (i % 3 == 0) ? 3'd6 : 3'd2;
            step(mvec_t'(r), p, "R4 R8 tiers");
        end

        // mixed random traffic
        for (int k = 0; k < 2000; k++)
            step(mvec_t'($urandom), PRIO_W'($urandom), "R3 R4 random");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule